// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block sits beside a small microcontroller-style core. It gathers five request sources: external input 0, timer 0, external input 1, timer 1 and the serial port. Each source raises a one-cycle event pulse, and the block latches that pulse into a pending flag. Software programs two byte-wide configuration registers. The enable register holds a master gate and one enable per source. The priority register places each source at a high or a low level.

From these registers, the pending flags and the current nesting state, the block picks one winner. It presents a request line, the winner's index, its level and its vector address to the CPU. When the CPU acknowledges, the block marks that level as in service. For the external and timer sources it also clears the pending flag by hardware. A return pulse from the CPU releases the innermost level in service. Only a high-level request may interrupt a low-level routine. Anything at the same or a lower level waits.

Top module: `irq_ctrl_core`

## Requirements
- R1: After a synchronous active-low reset, both configuration registers are zero, every pending flag is clear, both in-service bits are clear and `irq_req` is 0.
- R2: A high on `src_evt[i]` sets pending flag i on the next clock edge. The flag stays set until it is cleared, and it is visible on `pend_flags[i]`. Source index order is 0 = external 0, 1 = timer 0, 2 = external 1, 3 = timer 1, 4 = serial.
- R3: Enable register bit 7 is the master gate. While it is 0, `irq_req` stays 0 and the pending flags are kept unchanged.
- R4: Enable register bit i (i = 0..4) lets source i take part in arbitration. A pending source whose bit is 0 never wins. A write uses `cfg_sel` = 0 for the enable register and 1 for the priority register.
- R5: Priority register bit i = 1 puts source i at the high level. An eligible high-level source always wins over eligible low-level sources, and `irq_lvl_hi` shows the winner's level.
- R6: Inside one level, the lowest source index wins. So with the priority register at zero, external 0 beats both timers.
- R7: While `irq_req` is 1, `irq_src` holds the winner's index and `irq_vec` equals 0x0003 + 8 × index.
- R8: An accepted acknowledge sets the in-service bit of the winner's level (`ins_level[1]` high, `ins_level[0]` low). While the low bit is set, only high-level sources can request. While the high bit is set, no request is raised.
- R9: A pulse on `irq_ret` clears the high in-service bit if it is set, and otherwise clears the low one.
- R10: An accepted acknowledge clears the winner's pending flag when the winner is source 0..3. The serial flag (source 4) is not cleared by an acknowledge.
- R11: `flag_clr[i]` clears pending flag i. If an event arrives for the same source in the same cycle, the event wins.
- R12: An acknowledge has no effect when `irq_req` is 0 or when `irq_ret` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | Register select: 0 enable, 1 priority |
| cfg_wdata | input | 8 | Configuration write data |
| src_evt | input | 5 | Per-source event pulses |
| flag_clr | input | 5 | Software clear of pending flags |
| irq_ack | input | 1 | CPU accepts the presented vector |
| irq_ret | input | 1 | CPU return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to CPU |
| irq_src | output | 3 | Index of winning source |
| irq_vec | output | 16 | Vector address of winning source |
| irq_lvl_hi | output | 1 | Winner sits at the high level |
| pend_flags | output | 5 | Latched pending flags |
| ins_level | output | 2 | In-service bits {high, low} |

## Verification
A flag that was lost or wrongly cleared shows up on `pend_flags` one edge after the stimulus. If it wrongly survived an acknowledge, it appears again on `irq_req` in the next cycle. A corrupt in-service bit appears on `ins_level` at once. Within a cycle it also shows at the ports as a request that is wrongly held back or wrongly allowed through. An arbitration error shows up combinationally as a wrong `irq_src` or `irq_vec` in the same cycle the flags settle, so each one is caught one edge after the stimulus that caused it.

// File: rtl/irq_pkg.sv
// Package: shared constants and helpers for the interrupt controller.
// Assumes the source index order used throughout the block is the
// tie-break order inside a priority level.
package irq_pkg;

    localparam int IRQ_NUM_SRC  = 5;
    localparam int IRQ_SRC_W    = $clog2(IRQ_NUM_SRC);
    localparam int IRQ_VEC_W    = 16;
    localparam int IRQ_CFG_W    = 8;
    localparam int IRQ_GLB_BIT  = 7;
    localparam logic [IRQ_VEC_W-1:0] IRQ_VEC_BASE = 16'h0003;
    localparam int IRQ_VEC_SHIFT = 3;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } irq_lvl_e;

    // Vector address of a source index.
    function automatic logic [IRQ_VEC_W-1:0] irq_vec_of(input logic [IRQ_SRC_W-1:0] idx);
        logic [IRQ_VEC_W-1:0] wide;
        wide = IRQ_VEC_W'(idx);
        return IRQ_VEC_BASE + (wide << IRQ_VEC_SHIFT);
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
// Module: irq_cfg_regs
// Holds the enable and priority configuration registers.
// Assumes a single write port; cfg_sel 0 addresses enable, 1 priority.
module irq_cfg_regs #(
    parameter int N       = irq_pkg::IRQ_NUM_SRC,
    parameter int CFG_W   = irq_pkg::IRQ_CFG_W,
    parameter int GLB_BIT = irq_pkg::IRQ_GLB_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [N-1:0]     src_en,
    output logic             glb_en,
    output logic [N-1:0]     src_hi
);

    logic [CFG_W-1:0] en_q;
    logic [CFG_W-1:0] pr_q;

    // Register the enable byte on an enable-register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (cfg_wr && !cfg_sel)
            en_q <= cfg_wdata;
    end

    // Register the priority byte on a priority-register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pr_q <= '0;
        else if (cfg_wr && cfg_sel)
            pr_q <= cfg_wdata;
    end

    assign src_en = en_q[N-1:0];
    assign glb_en = en_q[GLB_BIT];
    assign src_hi = pr_q[N-1:0];

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{en_q[CFG_W-1:N], pr_q[CFG_W-1:N]};

    // R1
    // after reset the master gate is off
    glb_reset_chk: assert property (@(posedge clk) !rst_n |=> !glb_en);

endmodule

// File: rtl/irq_flag_bank.sv
// Module: irq_flag_bank
// Latches per-source event pulses into pending flags and clears them
// by software or, for sources in HW_CLR_MASK, on an accepted acknowledge.
// Assumes ack_fire is already qualified by a live request.
module irq_flag_bank #(
    parameter int              N           = irq_pkg::IRQ_NUM_SRC,
    parameter int              SRC_W       = irq_pkg::IRQ_SRC_W,
    parameter logic [N-1:0]    HW_CLR_MASK = 5'b01111
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     src_evt,
    input  logic [N-1:0]     flag_clr,
    input  logic             ack_fire,
    input  logic [SRC_W-1:0] ack_idx,
    output logic [N-1:0]     flags
);

    logic [N-1:0] flags_q;

    for (genvar gi = 0; gi < N; gi++) begin : g_flag
        logic hw_clr;
        if (HW_CLR_MASK[gi]) begin : g_hwclr
            assign hw_clr = ack_fire && (ack_idx == SRC_W'(gi));
        end else begin : g_swonly
            assign hw_clr = 1'b0;
        end

        // Set on event, otherwise hold unless cleared by software or ack.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_q[gi] <= 1'b0;
            else
                flags_q[gi] <= src_evt[gi] | (flags_q[gi] & ~flag_clr[gi] & ~hw_clr);
        end

        if (!HW_CLR_MASK[gi]) begin : g_keep_chk
            // R10
            sw_flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (flags_q[gi] && !flag_clr[gi]) |=> flags_q[gi]);
        end else begin : g_clr_chk
            // R10
            hw_flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_fire && ack_idx == SRC_W'(gi) && !src_evt[gi]) |=> !flags_q[gi]);
        end

        // R11
        evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            src_evt[gi] |=> flags_q[gi]);
    end

    assign flags = flags_q;

endmodule

// File: rtl/irq_arbiter.sv
// Module: irq_arbiter
// Combinational two-level selection of the winning source, gated by
// the master enable, per-source enables and the in-service state.
// Assumes lower index wins inside a level.
module irq_arbiter #(
    parameter int N     = irq_pkg::IRQ_NUM_SRC,
    parameter int SRC_W = irq_pkg::IRQ_SRC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     flags,
    input  logic [N-1:0]     src_en,
    input  logic             glb_en,
    input  logic [N-1:0]     src_hi,
    input  logic             ins_hi,
    input  logic             ins_lo,
    output logic             req,
    output logic [SRC_W-1:0] win_idx,
    output irq_pkg::irq_lvl_e win_lvl
);
    import irq_pkg::*;

    logic [N-1:0] elig;
    logic [N-1:0] hi_set;
    logic [N-1:0] lo_set;
    logic         hi_ok;
    logic         lo_ok;
    logic [SRC_W-1:0] hi_idx;
    logic [SRC_W-1:0] lo_idx;

    // Lowest set index of a vector (0 when empty).
    function automatic logic [SRC_W-1:0] first_set(input logic [N-1:0] v);
        logic [SRC_W-1:0] r;
        r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (v[i]) r = SRC_W'(i);
        end
        return r;
    endfunction

    // Split eligible sources by level.
    always_comb begin
        elig   = flags & src_en & {N{glb_en}};
        hi_set = elig & src_hi;
        lo_set = elig & ~src_hi;
    end

    // Pick per-level winners and apply the nesting rule.
    always_comb begin
        hi_idx  = first_set(hi_set);
        lo_idx  = first_set(lo_set);
        hi_ok   = (|hi_set) && !ins_hi;
        lo_ok   = (|lo_set) && !ins_hi && !ins_lo;
        req     = hi_ok || lo_ok;
        win_idx = hi_ok ? hi_idx : lo_idx;
        win_lvl = hi_ok ? LVL_HI : LVL_LO;
    end

    // R3
    glb_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> !req);

    // R8
    hi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_hi |-> !req);

    // R8
    lo_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_lo && req) |-> (win_lvl == LVL_HI));

    // R4
    win_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (flags[win_idx] && src_en[win_idx]));

endmodule

// File: rtl/irq_nest_tracker.sv
// Module: irq_nest_tracker
// Keeps one in-service bit per priority level. An accepted acknowledge
// sets the winner's level; a return clears the innermost level.
// Assumes ack_fire is never high in a cycle with ret high.
module irq_nest_tracker (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_fire,
    input  irq_pkg::irq_lvl_e ack_lvl,
    input  logic              ret,
    output logic              ins_hi,
    output logic              ins_lo
);
    import irq_pkg::*;

    logic hi_q;
    logic lo_q;

    // Update the high-level in-service bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_q <= 1'b0;
        else if (ret)
            hi_q <= 1'b0;
        else if (ack_fire && ack_lvl == LVL_HI)
            hi_q <= 1'b1;
    end

    // Update the low-level in-service bit; a return only reaches it when no high routine runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lo_q <= 1'b0;
        else if (ret && !hi_q)
            lo_q <= 1'b0;
        else if (!ret && ack_fire && ack_lvl == LVL_LO)
            lo_q <= 1'b1;
    end

    assign ins_hi = hi_q;
    assign ins_lo = lo_q;

    // R9
    ret_hi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && hi_q) |=> (!hi_q && lo_q == $past(lo_q)));

    // R9
    ret_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !hi_q) |=> !lo_q);

    // R8
    ack_hi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && ack_lvl == LVL_HI) |=> hi_q);

endmodule

// File: rtl/irq_ctrl_core.sv
// Module: irq_ctrl_core
// Top of the two-level interrupt controller: configuration registers,
// pending flags, arbitration and nesting state.
// Assumes irq_ack and irq_ret are single-cycle pulses from the CPU.
module irq_ctrl_core #(
    parameter int N     = irq_pkg::IRQ_NUM_SRC,
    parameter int SRC_W = irq_pkg::IRQ_SRC_W,
    parameter int CFG_W = irq_pkg::IRQ_CFG_W,
    parameter int VEC_W = irq_pkg::IRQ_VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [N-1:0]     src_evt,
    input  logic [N-1:0]     flag_clr,
    input  logic             irq_ack,
    input  logic             irq_ret,
    output logic             irq_req,
    output logic [SRC_W-1:0] irq_src,
    output logic [VEC_W-1:0] irq_vec,
    output logic             irq_lvl_hi,
    output logic [N-1:0]     pend_flags,
    output logic [1:0]       ins_level
);
    import irq_pkg::*;

    logic [N-1:0]     src_en;
    logic             glb_en;
    logic [N-1:0]     src_hi;
    logic [N-1:0]     flags;
    logic             ins_hi;
    logic             ins_lo;
    logic             req;
    logic [SRC_W-1:0] win_idx;
    irq_lvl_e         win_lvl;
    logic             ack_fire;

    irq_cfg_regs #(.N(N), .CFG_W(CFG_W), .GLB_BIT(IRQ_GLB_BIT)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .src_en    (src_en),
        .glb_en    (glb_en),
        .src_hi    (src_hi)
    );

    irq_flag_bank #(.N(N), .SRC_W(SRC_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_evt  (src_evt),
        .flag_clr (flag_clr),
        .ack_fire (ack_fire),
        .ack_idx  (win_idx),
        .flags    (flags)
    );

    irq_arbiter #(.N(N), .SRC_W(SRC_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (flags),
        .src_en  (src_en),
        .glb_en  (glb_en),
        .src_hi  (src_hi),
        .ins_hi  (ins_hi),
        .ins_lo  (ins_lo),
        .req     (req),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    irq_nest_tracker u_nest (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_fire (ack_fire),
        .ack_lvl  (win_lvl),
        .ret      (irq_ret),
        .ins_hi   (ins_hi),
        .ins_lo   (ins_lo)
    );

    // Qualify the acknowledge: needs a live request and no return this cycle.
    always_comb ack_fire = irq_ack && req && !irq_ret;

    // Drive the CPU-facing outputs.
    always_comb begin
        irq_req    = req;
        irq_src    = win_idx;
        irq_vec    = irq_vec_of(win_idx);
        irq_lvl_hi = (win_lvl == LVL_HI);
        pend_flags = flags;
        ins_level  = {ins_hi, ins_lo};
    end

    // R7
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[IRQ_VEC_SHIFT-1:0] == 3'b011));

    // R12
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !irq_req && !irq_ret) |=> $stable(ins_level));

endmodule

// File: tb/sim_irq_ctrl_core.sv
`timescale 1ns/1ps
module sim_irq_ctrl_core;

    localparam int N = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_wr;
    logic       cfg_sel;
    logic [7:0] cfg_wdata;
    logic [4:0] src_evt;
    logic [4:0] flag_clr;
    logic       irq_ack;
    logic       irq_ret;
    logic       irq_req;
    logic [2:0] irq_src;
    logic [15:0] irq_vec;
    logic       irq_lvl_hi;
    logic [4:0] pend_flags;
    logic [1:0] ins_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctrl_core u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .src_evt(src_evt), .flag_clr(flag_clr),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
        .irq_src(irq_src), .irq_vec(irq_vec), .irq_lvl_hi(irq_lvl_hi),
        .pend_flags(pend_flags), .ins_level(ins_level)
    );

    // Bench model state, built from the requirements.
    logic [7:0] m_en, m_pr;
    logic [4:0] m_flags;
    logic       m_ish, m_isl;
    logic       m_req, m_hi;
    logic [2:0] m_idx;

    function automatic void model_reset();
        m_en = '0; m_pr = '0; m_flags = '0; m_ish = 0; m_isl = 0;
    endfunction

    function automatic void model_win();
        logic [4:0] el, hs, ls;
        el = m_flags & m_en[4:0] & {5{m_en[7]}};
        hs = el & m_pr[4:0];
        ls = el & ~m_pr[4:0];
        m_req = 0; m_hi = 0; m_idx = 0;
        if (|hs && !m_ish) begin
            m_req = 1; m_hi = 1;
            for (int i = 4; i >= 0; i--) if (hs[i]) m_idx = 3'(i);
        end else if (|ls && !m_ish && !m_isl) begin
            m_req = 1;
            for (int i = 4; i >= 0; i--) if (ls[i]) m_idx = 3'(i);
        end
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        model_win();
        check(irq_req == m_req, tag, "irq_req", irq_req, m_req);
        check(pend_flags == m_flags, tag, "pend_flags", pend_flags, m_flags);
        check(ins_level == {m_ish, m_isl}, tag, "ins_level", ins_level, {m_ish, m_isl});
        if (m_req) begin
            check(irq_src == m_idx, tag, "irq_src", irq_src, m_idx);
            check(irq_vec == 16'h0003 + 16'(m_idx) * 8, tag, "irq_vec",
                  irq_vec, 16'h0003 + 16'(m_idx) * 8);
            check(irq_lvl_hi == m_hi, tag, "irq_lvl_hi", irq_lvl_hi, m_hi);
        end
    endtask

    // One clock: drive inputs, advance the model, compare after the edge.
    task automatic step(input string tag, input bit wr, input bit sel,
                        input logic [7:0] wd, input logic [4:0] ev,
                        input logic [4:0] cl, input bit ak, input bit rt);
        bit ack_ok;
        cfg_wr = wr; cfg_sel = sel; cfg_wdata = wd;
        src_evt = ev; flag_clr = cl; irq_ack = ak; irq_ret = rt;
        model_win();
        ack_ok = ak && m_req && !rt;
        for (int i = 0; i < N; i++)
            m_flags[i] = ev[i] | (m_flags[i] & ~cl[i] &
                         ~(ack_ok && m_idx == 3'(i) && i < 4));
        if (rt) begin
            if (m_ish) m_ish = 0; else m_isl = 0;
        end else if (ack_ok) begin
            if (m_hi) m_ish = 1; else m_isl = 1;
        end
        if (wr) begin
            if (sel) m_pr = wd; else m_en = wd;
        end
        @(posedge clk); #1;
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 8'h00, 5'h0, 5'h0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c3a5));
        rst_n = 0; cfg_wr = 0; cfg_sel = 0; cfg_wdata = 0;
        src_evt = 0; flag_clr = 0; irq_ack = 0; irq_ret = 0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        model_reset();
        compare("R1");

        // R2, R3: events latch but master gate off keeps request low
        step("R2", 0, 0, 8'h00, 5'b10101, 5'h0, 0, 0);
        step("R3", 0, 0, 8'h1F, 5'h0, 5'h0, 0, 0);
        idle("R3");
        check(irq_req == 0 && pend_flags == 5'b10101, "R3", "gated",
              {irq_req, pend_flags}, 6'b010101);
        // R4: master on, only serial enabled
        step("R4", 1, 0, 8'h90, 5'h0, 5'h0, 0, 0);
        check(irq_req && irq_src == 3'd4, "R4", "serial only", irq_src, 4);
        // R6: all enabled, low level, external 0 wins
        step("R6", 1, 0, 8'h9F, 5'b01010, 5'h0, 0, 0);
        check(irq_src == 3'd0 && irq_vec == 16'h0003, "R6", "tie", irq_vec, 16'h0003);
        // R5: timer 1 high priority beats external 0
        step("R5", 1, 1, 8'h08, 5'h0, 5'h0, 0, 0);
        check(irq_src == 3'd3 && irq_lvl_hi, "R5", "hi wins", irq_src, 3);
        // R7: vector of timer 1
        check(irq_vec == 16'h001B, "R7", "vec t1", irq_vec, 16'h001B);
        // R8, R10: ack high, flag 3 cleared, request blocked
        step("R8", 0, 0, 8'h00, 5'h0, 5'h0, 1, 0);
        check(ins_level == 2'b10 && !irq_req && !pend_flags[3], "R10", "ack hi",
              {ins_level, irq_req, pend_flags[3]}, 4'b1000);
        // R12: ack with no request has no effect
        step("R12", 0, 0, 8'h00, 5'h0, 5'h0, 1, 0);
        check(ins_level == 2'b10, "R12", "idle ack", ins_level, 2'b10);
        // R9: return clears high level
        step("R9", 0, 0, 8'h00, 5'h0, 5'h0, 0, 1);
        check(ins_level == 2'b00 && irq_src == 3'd0, "R9", "ret hi", ins_level, 0);
        // R8: ack low (ext 0), then higher preempts
        step("R8", 0, 0, 8'h00, 5'h0, 5'h0, 1, 0);
        check(ins_level == 2'b01 && !irq_req, "R8", "lo blocks lo",
              {ins_level, irq_req}, 3'b010);
        step("R8", 0, 0, 8'h00, 5'b01000, 5'h0, 0, 0);
        check(irq_req && irq_lvl_hi, "R8", "hi preempts", irq_req, 1);
        // R12: ack together with return is dropped
        step("R12", 0, 0, 8'h00, 5'h0, 5'h0, 1, 1);
        check(ins_level == 2'b00 && pend_flags[3], "R12", "ack+ret",
              {ins_level, pend_flags[3]}, 3'b001);
        // R10: serial flag survives its own ack
        step("R10", 1, 1, 8'h10, 5'h0, 5'b01111, 0, 0);
        step("R10", 0, 0, 8'h00, 5'h0, 5'h0, 1, 0);
        check(pend_flags[4] == 1, "R10", "serial kept", pend_flags[4], 1);
        step("R9", 0, 0, 8'h00, 5'h0, 5'h0, 0, 1);
        // R11: clear and event same cycle; then plain clear
        step("R11", 0, 0, 8'h00, 5'b10000, 5'b10000, 0, 0);
        check(pend_flags[4] == 1, "R11", "evt wins", pend_flags[4], 1);
        step("R11", 0, 0, 8'h00, 5'h0, 5'b10000, 0, 0);
        check(pend_flags[4] == 0, "R11", "sw clear", pend_flags[4], 0);

        // Constrained random phase against the model.
        for (int n = 0; n < 3000; n++) begin
            bit wr, sel, ak, rt;
            logic [7:0] wd;
            logic [4:0] ev, cl;
            wr  = ($urandom % 12) == 0;
            sel = $urandom % 2;
            wd  = 8'($urandom);
            if (!sel && ($urandom % 4) != 0) wd[7] = 1'b1;
            ev  = 5'($urandom) & 5'($urandom) & 5'($urandom);
            cl  = (($urandom % 6) == 0) ? 5'($urandom) : 5'h0;
            ak  = ($urandom % 3) == 0;
            rt  = ($urandom % 7) == 0;
            step("R6", wr, sel, wd, ev, cl, ak, rt);
        end

        // R1: reset again mid-run
        rst_n = 0;
        @(posedge clk); #1;
        rst_n = 1;
        model_reset();
        compare("R1");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule